// File: doc/BRIEF.md
# Voltage-Frequency Search Controller

This controller closes the loop between a requested core supply level, a run-time reconfigurable clock synthesizer and a set of in-path timing detectors whose outputs arrive already OR-ed into one violation flag. When a supply request arrives, the controller moves the regulator to the requested potentiometer code one code per SPI frame. It then walks a built-in table of multiplier/divider settings upward, one entry at a time. After each table write it waits for the synthesizer to relock and then watches the detectors for a programmable window.

When the detectors stay quiet for the whole window, the controller moves to the next faster entry. When they fire, it returns to the previous entry and holds it. From then on, further frequency increases wait until a request for a higher supply arrives. User logic gets a clock enable that is low from the first setting write until relock is seen. The enable stays high while the supply is being moved.

Top module: `vf_search_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, spiCsN is 1, spiSclk is 0, userClkEn is 0 and cfgWe is 0.
- R2: A requested code above CODE_LIMIT (default 200) is replaced by CODE_LIMIT. Code 0 is the highest supply and larger codes give lower supplies.
- R3: Each SPI frame is 16 bits in mode 0, MSB first, sent with spiCsN low for the whole frame. Bits 15:8 carry SPI_CMD (default 8'h05) and bits 7:0 carry the new code. The codes in consecutive frames move by exactly 1 toward the target. The first frame starts from RESET_CODE (default 0).
- R4: Once the user clock is running, userClkEn stays 1 during supply changes.
- R5: Table entry i has multiplier MUL_FIRST+i (default 2+i) and divider DIV_FIX (default 8). Each setting is written as two back-to-back cycles of cfgWe: first with cfgAddr=0 and the multiplier, then with cfgAddr=1 and the divider.
- R6: userClkEn is 0 in every cycle in which cfgWe is 1. It stays 0 after the divider write until synthLocked is seen high, at least LOCK_BLANK cycles later.
- R7: The first search after reset starts at entry 0. After every detector window with no violation, the next entry is written. With the user clock running, that window lasts obsLen cycles plus one step cycle.
- R8: A violation during the window causes the previous entry to be written and then held. A violation at entry 0 holds entry 0.
- R9: While holding, the violation input is ignored. A request whose clamped code is not below the current code is also ignored: no frame and no setting write.
- R10: While holding after a violation, a request for a higher supply moves the supply, watches the held entry again and then resumes the upward walk.
- R11: A clean window at the last table entry holds that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voltReqValid | input | 1 | One-cycle strobe that presents a new supply request |
| voltReq | input | 8 | Requested potentiometer code (0 is the highest supply) |
| obsLen | input | 16 | Length of the detector window, in cycles |
| violation | input | 1 | OR of all timing detector outputs |
| synthLocked | input | 1 | Lock indication from the clock synthesizer |
| cfgWe | output | 1 | Write strobe of the synthesizer setting port |
| cfgAddr | output | 1 | Setting register select: 0 multiplier, 1 divider |
| cfgWdata | output | 8 | Setting write data |
| userClkEn | output | 1 | Clock enable for user logic |
| spiCsN | output | 1 | Potentiometer chip select, active low |
| spiSclk | output | 1 | Potentiometer serial clock |
| spiMosi | output | 1 | Potentiometer serial data |

## Verification
The assertions assume that the synthesizer drops lock only after it has been given a new setting, and that it stays locked otherwise. This is what lets a running user clock imply a locked synthesizer. They also assume RESET_CODE is within CODE_LIMIT. The bench's synthesizer model lowers lock on each divider write and raises it a fixed number of cycles later. Its detector model fires only while the user clock runs at an entry beyond a safe index derived from the last code received over SPI. The only exception is a deliberate pulse sent while the controller is holding.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET_VOLT,
    ST_WAIT_SETTLE,
    ST_WRITE_CFG,
    ST_WAIT_LOCK,
    ST_OBSERVE,
    ST_STEP_UP,
    ST_HOLD
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic voltLoad;
    logic voltStep;
    logic cfgWrite;
    logic idxInc;
    logic idxDec;
    logic timerClr;
    logic clkRunSet;
    logic clkRunClr;
  } ctrlStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic targetHit;
    logic reqHigher;
    logic settleDone;
    logic cfgDone;
    logic lockReady;
    logic obsDone;
    logic idxAtTop;
    logic idxAtZero;
  } dpStatus_t;

endpackage

// File: rtl/vfs_freq_rom.sv
module vfs_freq_rom #(
  parameter int TBL_LEN   = 16,
  parameter int IDX_W     = $clog2(TBL_LEN),
  parameter int CFG_W     = 8,
  parameter int MUL_FIRST = 2,
  parameter int DIV_FIX   = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [CFG_W-1:0] mult,
  output logic [CFG_W-1:0] div
);

  // constant table: one multiplier step per entry keeps neighbouring periods close
  logic [CFG_W-1:0] multTbl [TBL_LEN];

  for (genvar i = 0; i < TBL_LEN; i++) begin : g_entry
    assign multTbl[i] = CFG_W'(MUL_FIRST + i);
  end

  assign mult = multTbl[idx];
  assign div  = CFG_W'(DIV_FIX);

endmodule

// File: rtl/vfs_spi_tx.sv
module vfs_spi_tx #(
  parameter int FRAME_W   = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic               csN
);

  localparam int HALF_W = $clog2(SCLK_HALF + 1);
  localparam int BIT_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shiftReg;
  logic [HALF_W-1:0]  divCnt;
  logic [BIT_W-1:0]   bitCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      busy     <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        shiftReg <= frame;
        busy     <= 1'b1;
        csN      <= 1'b0;
        divCnt   <= '0;
        bitCnt   <= '0;
        sclk     <= 1'b0;
      end
    end else if (divCnt == HALF_W'(SCLK_HALF - 1)) begin
      divCnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (bitCnt == BIT_W'(FRAME_W - 1)) begin
          busy <= 1'b0;
          csN  <= 1'b1;
        end else begin
          bitCnt   <= bitCnt + BIT_W'(1);
          shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
        end
      end
    end else begin
      divCnt <= divCnt + HALF_W'(1);
    end
  end

  assign mosi = shiftReg[FRAME_W-1];

  // R3: the serial clock idles low whenever the device is deselected
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sclk);

  // R3: chip select does not return high until all bits of the frame have been shifted out
  p_cs_whole_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && bitCnt != BIT_W'(FRAME_W - 1)) |=> !csN);

endmodule

// File: rtl/vfs_datapath.sv
module vfs_datapath
  import vfs_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int CODE_LIMIT = 200,
  parameter int RESET_CODE = 0,
  parameter int SPI_CMD    = 8'h05,
  parameter int SCLK_HALF  = 2,
  parameter int SETTLE_CYC = 4,
  parameter int LOCK_BLANK = 2,
  parameter int TBL_LEN    = 16,
  parameter int MUL_FIRST  = 2,
  parameter int DIV_FIX    = 8,
  parameter int CFG_W      = 8,
  parameter int OBS_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       s,
  output dpStatus_t         st,
  input  logic [CODE_W-1:0] voltReq,
  input  logic [OBS_W-1:0]  obsLen,
  input  logic              synthLocked,
  output logic              cfgWe,
  output logic              cfgAddr,
  output logic [CFG_W-1:0]  cfgWdata,
  output logic              userClkEn,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi
);

  localparam int IDX_W   = $clog2(TBL_LEN);
  localparam int FRAME_W = 8 + CODE_W;
  localparam int TMR_W   = OBS_W;

  logic [CODE_W-1:0] curCode, tgtCode, reqClamped, nextCode;
  logic [IDX_W-1:0]  idx;
  logic              cfgPhase;
  logic [TMR_W-1:0]  timer;
  logic              clkRun;
  logic              spiBusy;
  logic [CFG_W-1:0]  romMult, romDiv;

  // ---------------- supply code ----------------
  assign reqClamped = (voltReq > CODE_W'(CODE_LIMIT)) ? CODE_W'(CODE_LIMIT) : voltReq;
  assign nextCode   = (tgtCode > curCode) ? curCode + CODE_W'(1) : curCode - CODE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curCode <= CODE_W'(RESET_CODE);
      tgtCode <= CODE_W'(RESET_CODE);
    end else begin
      if (s.voltLoad) tgtCode <= reqClamped;
      if (s.voltStep) curCode <= nextCode;
    end
  end

  vfs_spi_tx #(
    .FRAME_W  (FRAME_W),
    .SCLK_HALF(SCLK_HALF)
  ) u_spi (
    .clk  (clk),
    .rst_n(rst_n),
    .start(s.voltStep),
    .frame({8'(SPI_CMD), nextCode}),
    .busy (spiBusy),
    .sclk (spiSclk),
    .mosi (spiMosi),
    .csN  (spiCsN)
  );

  // ---------------- table index and setting port ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      cfgPhase <= 1'b0;
    end else begin
      if (s.idxInc)        idx <= idx + IDX_W'(1);
      else if (s.idxDec)   idx <= idx - IDX_W'(1);
      if (s.cfgWrite)      cfgPhase <= ~cfgPhase;
    end
  end

  vfs_freq_rom #(
    .TBL_LEN  (TBL_LEN),
    .IDX_W    (IDX_W),
    .CFG_W    (CFG_W),
    .MUL_FIRST(MUL_FIRST),
    .DIV_FIX  (DIV_FIX)
  ) u_rom (
    .idx (idx),
    .mult(romMult),
    .div (romDiv)
  );

  assign cfgWe    = s.cfgWrite;
  assign cfgAddr  = cfgPhase;
  assign cfgWdata = cfgPhase ? romDiv : romMult;

  // ---------------- shared timer (settle, lock blanking, window) ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (s.timerClr || spiBusy) begin
      timer <= '0;
    end else if (timer != '1) begin
      timer <= timer + TMR_W'(1);
    end
  end

  // ---------------- user clock enable ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            clkRun <= 1'b0;
    else if (s.clkRunClr)  clkRun <= 1'b0;
    else if (s.clkRunSet)  clkRun <= 1'b1;
  end

  assign userClkEn = clkRun;

  // ---------------- status ----------------
  always_comb begin
    st            = '0;
    st.targetHit  = (curCode == tgtCode);
    st.reqHigher  = (reqClamped < curCode);
    st.settleDone = !spiBusy && (timer >= TMR_W'(SETTLE_CYC));
    st.cfgDone    = cfgPhase;
    st.lockReady  = synthLocked && (timer >= TMR_W'(LOCK_BLANK));
    st.obsDone    = ({1'b0, timer} + (OBS_W+1)'(1)) >= {1'b0, obsLen};
    st.idxAtTop   = (idx == IDX_W'(TBL_LEN - 1));
    st.idxAtZero  = (idx == '0);
  end

  // R2: the applied code never exceeds the minimum-supply limit
  p_code_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    curCode <= CODE_W'(CODE_LIMIT));

  // R3: the applied code moves by one per update
  p_code_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curCode) |-> (curCode == $past(curCode) + CODE_W'(1) ||
                           curCode == $past(curCode) - CODE_W'(1)));

  // R3: the code changes only when a frame carrying it starts
  p_code_with_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curCode) |-> $fell(spiCsN));

  // R7: table walk never skips entries
  p_idx_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx) |-> (idx == $past(idx) + IDX_W'(1) || idx == $past(idx) - IDX_W'(1)));

  // R6: user logic is stalled while a setting is written
  p_gate_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWe |-> !userClkEn);

  // R6: a running user clock always comes from a locked synthesizer
  p_run_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    userClkEn |-> synthLocked);

  // R5: multiplier write is followed at once by the divider write
  p_pair_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && !cfgAddr) |=> (cfgWe && cfgAddr));

endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        voltReqValid,
  input  logic        violation,
  input  dpStatus_t   st,
  output ctrlStrobe_t s
);

  ctrlState_e state, nxt;
  logic       resume;   // request arrived while holding
  logic       fired;    // detectors fired at the entry above the held one

  always_comb begin
    nxt = state;
    s   = '0;
    unique case (state)
      ST_IDLE: begin
        if (voltReqValid) begin
          s.voltLoad = 1'b1;
          nxt        = ST_SET_VOLT;
        end
      end
      ST_HOLD: begin
        if (voltReqValid && st.reqHigher) begin
          s.voltLoad = 1'b1;
          nxt        = ST_SET_VOLT;
        end
      end
      ST_SET_VOLT: begin
        if (!st.targetHit) begin
          s.voltStep = 1'b1;
          nxt        = ST_WAIT_SETTLE;
        end else if (!resume) begin
          nxt = ST_WRITE_CFG;
        end else if (fired) begin
          s.timerClr = 1'b1;
          nxt        = ST_OBSERVE;
        end else begin
          nxt = ST_HOLD;
        end
      end
      ST_WAIT_SETTLE: begin
        if (st.settleDone) nxt = ST_SET_VOLT;
      end
      ST_WRITE_CFG: begin
        s.cfgWrite = 1'b1;
        if (st.cfgDone) begin
          s.timerClr = 1'b1;
          nxt        = ST_WAIT_LOCK;
        end
      end
      ST_WAIT_LOCK: begin
        if (st.lockReady) begin
          s.clkRunSet = 1'b1;
          s.timerClr  = 1'b1;
          nxt         = fired ? ST_HOLD : ST_OBSERVE;
        end
      end
      ST_OBSERVE: begin
        if (violation) begin
          if (!st.idxAtZero) begin
            s.idxDec = 1'b1;
            nxt      = ST_WRITE_CFG;
          end else begin
            nxt = ST_HOLD;
          end
        end else if (st.obsDone) begin
          nxt = st.idxAtTop ? ST_HOLD : ST_STEP_UP;
        end
      end
      ST_STEP_UP: begin
        s.idxInc = 1'b1;
        nxt      = ST_WRITE_CFG;
      end
      default: nxt = ST_IDLE;
    endcase
    s.clkRunClr = (nxt == ST_WRITE_CFG) && (state != ST_WRITE_CFG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      resume <= 1'b0;
      fired  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && voltReqValid)               resume <= 1'b0;
      else if (state == ST_HOLD && s.voltLoad)            resume <= 1'b1;
      if (state == ST_OBSERVE && violation)               fired <= 1'b1;
      else if (state == ST_SET_VOLT && nxt == ST_OBSERVE) fired <= 1'b0;
    end
  end

  // R9: holding never writes a setting unless a higher supply was requested first
  p_hold_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !(voltReqValid && st.reqHigher)) |=> !s.cfgWrite);

  // R8: a violation away from entry 0 leads straight to a setting write
  p_backoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OBSERVE && violation && !st.idxAtZero) |=> s.cfgWrite);

  // R10: after a firing, a completed supply raise re-enters the detector window
  p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SET_VOLT && st.targetHit && resume && fired) |=> state == ST_OBSERVE);

endmodule

// File: rtl/vf_search_ctrl.sv
module vf_search_ctrl
  import vfs_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int CODE_LIMIT = 200,
  parameter int RESET_CODE = 0,
  parameter int SPI_CMD    = 8'h05,
  parameter int SCLK_HALF  = 2,
  parameter int SETTLE_CYC = 4,
  parameter int LOCK_BLANK = 2,
  parameter int TBL_LEN    = 16,
  parameter int MUL_FIRST  = 2,
  parameter int DIV_FIX    = 8,
  parameter int CFG_W      = 8,
  parameter int OBS_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              voltReqValid,
  input  logic [CODE_W-1:0] voltReq,
  input  logic [OBS_W-1:0]  obsLen,
  input  logic              violation,
  input  logic              synthLocked,
  output logic              cfgWe,
  output logic              cfgAddr,
  output logic [CFG_W-1:0]  cfgWdata,
  output logic              userClkEn,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  vfs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .voltReqValid(voltReqValid),
    .violation   (violation),
    .st          (status),
    .s           (strobe)
  );

  vfs_datapath #(
    .CODE_W    (CODE_W),
    .CODE_LIMIT(CODE_LIMIT),
    .RESET_CODE(RESET_CODE),
    .SPI_CMD   (SPI_CMD),
    .SCLK_HALF (SCLK_HALF),
    .SETTLE_CYC(SETTLE_CYC),
    .LOCK_BLANK(LOCK_BLANK),
    .TBL_LEN   (TBL_LEN),
    .MUL_FIRST (MUL_FIRST),
    .DIV_FIX   (DIV_FIX),
    .CFG_W     (CFG_W),
    .OBS_W     (OBS_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .s          (strobe),
    .st         (status),
    .voltReq    (voltReq),
    .obsLen     (obsLen),
    .synthLocked(synthLocked),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgWdata   (cfgWdata),
    .userClkEn  (userClkEn),
    .spiCsN     (spiCsN),
    .spiSclk    (spiSclk),
    .spiMosi    (spiMosi)
  );

endmodule

// File: tb/sim_vf_search_ctrl.sv
module sim_vf_search_ctrl;

  localparam int TBL_LEN   = 16;
  localparam int MUL_FIRST = 2;
  localparam int DIV_FIX   = 8;
  localparam int SPI_CMD   = 8'h05;
  localparam int CODE_LIM  = 200;
  localparam int OBS       = 20;
  localparam int LOCK_LAT  = 6;
  localparam int WDOG      = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       voltReqValid;
  logic [7:0] voltReq;
  logic [15:0] obsLen;
  logic       violation;
  logic       synthLocked;
  logic       cfgWe, cfgAddr, userClkEn, spiCsN, spiSclk, spiMosi;
  logic [7:0] cfgWdata;

  always #4 clk = ~clk;

  vf_search_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .voltReqValid(voltReqValid), .voltReq(voltReq),
    .obsLen(obsLen), .violation(violation), .synthLocked(synthLocked),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .userClkEn(userClkEn),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural models ----------------
  int vCode = 0;          // regulator code last received
  int synthIdx = 0;       // entry the synthesizer runs at
  int lockCnt = 0;
  bit forceViol = 1'b0;
  int expFrames[$];
  int gotWrites[$];
  int expWrites[$];
  int pendMult = -1;
  int prevIdx = -5;
  int hiCnt = 0;
  int offDuringSpi = 0;
  int spiBits = 0;
  logic [15:0] spiSh;

  function automatic int safeIdx(input int code);
    return 16 - code / 4;
  endfunction

  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      spiSh = {spiSh[14:0], spiMosi};
      spiBits++;
    end
  end

  always @(posedge spiCsN) begin
    if (spiBits != 0) begin
      check(spiBits == 16, "R3", "frame bit count", spiBits, 16);
      check(int'(spiSh[15:8]) == SPI_CMD, "R3", "command byte", int'(spiSh[15:8]), SPI_CMD);
      if (expFrames.size() == 0) begin
        check(1'b0, "R3", "unexpected frame code", int'(spiSh[7:0]), -1);
      end else begin
        int e;
        e = expFrames.pop_front();
        check(int'(spiSh[7:0]) == e, "R3", "frame code", int'(spiSh[7:0]), e);
      end
      vCode = int'(spiSh[7:0]);
      spiBits = 0;
    end
  end

  // per-cycle reference comparison and synthesizer/detector models
  always @(negedge clk) begin
    if (rst_n) begin
      check(!(cfgWe && userClkEn), "R6", "clock enable during write", int'(userClkEn), 0);
      check(!(userClkEn && !synthLocked), "R6", "clock enable before lock", int'(userClkEn), 0);
      if (!spiCsN && !userClkEn) offDuringSpi++;
      if (cfgWe && !cfgAddr) begin
        int idx;
        idx = int'(cfgWdata) - MUL_FIRST;
        if (prevIdx >= 0 && idx == prevIdx + 1)
          check(hiCnt == OBS + 1, "R7", "enabled cycles in clean window", hiCnt, OBS + 1);
        pendMult = int'(cfgWdata);
      end else if (cfgWe && cfgAddr) begin
        check(pendMult >= 0, "R5", "divider write follows multiplier", pendMult, 0);
        check(int'(cfgWdata) == DIV_FIX, "R5", "divider value", int'(cfgWdata), DIV_FIX);
        synthIdx = pendMult - MUL_FIRST;
        gotWrites.push_back(synthIdx);
        prevIdx = synthIdx;
        pendMult = -1;
        hiCnt = 0;
        lockCnt = LOCK_LAT;
        synthLocked = 1'b0;
      end else begin
        if (pendMult >= 0) begin
          check(1'b0, "R5", "multiplier without divider", pendMult, -1);
          pendMult = -1;
        end
        if (lockCnt > 0) lockCnt--;
        if (lockCnt == 0) synthLocked = 1'b1;
      end
      if (userClkEn) hiCnt++;
      violation = (userClkEn && synthIdx > safeIdx(vCode)) || forceViol;
    end
  end

  // ---------------- helpers ----------------
  task automatic expSteps(input int fromC, input int toC);
    int c;
    c = fromC;
    while (c != toC) begin
      c = (toC > c) ? c + 1 : c - 1;
      expFrames.push_back(c);
    end
  endtask

  task automatic expClimb(input int first, input int safe);
    int last;
    last = safe + 1;
    if (last > TBL_LEN - 1) last = TBL_LEN - 1;
    if (last < first) last = first;
    for (int i = first; i <= last; i++) expWrites.push_back(i);
    if (safe + 1 <= TBL_LEN - 1 && safe >= 0) expWrites.push_back(safe);
  endtask

  task automatic sendReq(input int code);
    @(negedge clk);
    voltReqValid = 1'b1;
    voltReq = 8'(code);
    @(negedge clk);
    voltReqValid = 1'b0;
  endtask

  task automatic waitQuiet();
    int q;
    q = 0;
    while (q < 300) begin
      @(negedge clk);
      if (cfgWe || !spiCsN) q = 0;
      else q++;
    end
  endtask

  task automatic compareWrites(input string req);
    check(gotWrites.size() == expWrites.size(), req, "setting write count",
          gotWrites.size(), expWrites.size());
    for (int i = 0; i < expWrites.size() && i < gotWrites.size(); i++)
      check(gotWrites[i] == expWrites[i], req, "written entry", gotWrites[i], expWrites[i]);
    check(expFrames.size() == 0, "R3", "frames still expected", expFrames.size(), 0);
    gotWrites.delete();
    expWrites.delete();
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(spiCsN == 1'b1 && spiSclk == 1'b0, "R1", "spi idle in reset", int'({spiCsN, spiSclk}), 2);
    check(userClkEn == 1'b0 && cfgWe == 1'b0, "R1", "enable/write in reset", int'({userClkEn, cfgWe}), 0);
    vCode = 0; synthIdx = 0; lockCnt = 0; synthLocked = 1'b1; pendMult = -1; spiBits = 0;
    rst_n = 1'b1;
    @(negedge clk);
    check(spiCsN == 1'b1 && spiSclk == 1'b0, "R1", "spi idle after reset", int'({spiCsN, spiSclk}), 2);
    check(userClkEn == 1'b0 && cfgWe == 1'b0, "R1", "enable/write after reset", int'({userClkEn, cfgWe}), 0);
  endtask

  // watchdog
  initial begin
    repeat (WDOG) @(negedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R7 watchdog: cycles=%0d expected<%0d", WDOG, WDOG);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    voltReqValid = 1'b0;
    voltReq = '0;
    obsLen = 16'(OBS);
    violation = 1'b0;
    synthLocked = 1'b1;
    doReset();

    // A: first search from entry 0 (R7 R8)
    prevIdx = -5;
    expSteps(0, 20);
    expClimb(0, safeIdx(20));
    sendReq(20);
    waitQuiet();
    compareWrites("R7 R8");
    check(userClkEn == 1'b1, "R6", "clock running after relock", int'(userClkEn), 1);

    // B: holding ignores lower supply requests and detector pulses (R9)
    sendReq(30);
    waitQuiet();
    forceViol = 1'b1;
    repeat (6) @(negedge clk);
    forceViol = 1'b0;
    waitQuiet();
    check(gotWrites.size() == 0, "R9", "writes while holding", gotWrites.size(), 0);
    check(vCode == 20, "R9", "regulator code while holding", vCode, 20);
    check(userClkEn == 1'b1, "R9", "clock still running", int'(userClkEn), 1);

    // C: higher supply resumes climbing, clock kept during change (R10 R4)
    prevIdx = -5;
    offDuringSpi = 0;
    expSteps(20, 12);
    expClimb(safeIdx(20) + 1, safeIdx(12));
    sendReq(12);
    waitQuiet();
    compareWrites("R10");
    check(offDuringSpi == 0, "R4", "gated cycles during supply change", offDuringSpi, 0);

    // D: climb reaches the last entry and holds it (R11)
    prevIdx = -5;
    offDuringSpi = 0;
    expSteps(12, 0);
    expClimb(safeIdx(12) + 1, safeIdx(0));
    sendReq(0);
    waitQuiet();
    compareWrites("R11");
    check(synthIdx == TBL_LEN - 1, "R11", "held entry", synthIdx, TBL_LEN - 1);
    check(offDuringSpi == 0, "R4", "gated cycles during supply change", offDuringSpi, 0);

    // E: clamp of an oversized request, violation at entry 0 (R2 R8)
    doReset();
    prevIdx = -5;
    expSteps(0, CODE_LIM);
    expClimb(0, safeIdx(CODE_LIM));
    sendReq(255);
    waitQuiet();
    compareWrites("R8");
    check(vCode == CODE_LIM, "R2", "clamped final code", vCode, CODE_LIM);
    check(synthIdx == 0, "R8", "held entry after entry-0 firing", synthIdx, 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule